// File: doc/BRIEF.md
# 8-bit Read-Modify-Write Shift and Step Unit

This unit executes the second instruction group of a small 8-bit accumulator processor. A 3-bit function code selects one of eight operations:

- four single-place shifts or rotates through carry;
- a store of the X register;
- a load of X;
- a decrement and an increment of a memory operand.

The surrounding sequencer fetches the operand from the accumulator or from memory, supplies the current carry and X, and raises `start` for one cycle.

One clock later the unit presents a registered result together with the new carry, negative and zero flags. Each flag has its own update enable, so the sequencer can tell which flags the operation touched. The unit also raises at most one of three write enables: accumulator, X register or memory, the last with its data. A `done` strobe marks the cycle in which all of these are valid.

Address generation and bus timing stay outside. The effective address never enters the unit; only the write intent and the data leave it.

Top module: `rmw_shift_unit`

## Requirements
- R1: Function code 000 shifts left with 0 into bit 0. Code 001 shifts left with the incoming carry into bit 0. Both set the new carry to the old bit 7 (0x98 gives 0x30 with carry 1; 0x80 with carry 1 gives 0x01 with carry 1).
- R2: Function code 010 shifts right with 0 into bit 7. Code 011 shifts right with the incoming carry into bit 7. Both set the new carry to the old bit 0 (0x81 gives 0x40 with carry 1; 0x81 with carry 1 gives 0xC0 with carry 1 and negative 1).
- R3: For shifts, rotates, load-X (101), decrement (110) and increment (111), the negative and zero update enables are 1. The negative output equals bit 7 of the result, and the zero output is 1 exactly when the result is 0x00, so both flags are cleared as well as set.
- R4: For codes 000 to 011, an asserted accumulator-mode input raises only the accumulator write enable. Otherwise only the memory write enable is raised, with the memory data equal to the result. All four update carry.
- R5: Store-X (100) raises only the memory write enable, with data and result equal to the X input. All flag update enables stay 0, and the carry output equals the incoming carry.
- R6: Load-X (101) makes the result equal to the operand and raises only the X write enable. Carry is not updated and passes through unchanged.
- R7: Decrement and increment wrap modulo 256 (0x00 decrements to 0xFF, 0xFF increments to 0x00). They always raise the memory write enable, whatever the accumulator-mode input, and never update carry.
- R8: All outputs are registered and reflect the operation one clock after `start`. `done` is high for exactly that cycle. In a cycle without a preceding `start`, `done` and every enable are 0 and the result, flag values and memory data hold.
- R9: Synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Execute the operation presented this cycle |
| func | input | 3 | Function code (000..111 as in R1 to R7) |
| operand | input | 8 | Operand from accumulator or memory |
| acc_mode | input | 1 | Accumulator is the source and target of a shift |
| carry_in | input | 1 | Current carry flag |
| x_in | input | 8 | Current X register |
| result | output | 8 | Operation result |
| carry_out | output | 1 | New carry value |
| neg_out | output | 1 | New negative value |
| zero_out | output | 1 | New zero value |
| carry_upd | output | 1 | Carry flag update enable |
| neg_upd | output | 1 | Negative flag update enable |
| zero_upd | output | 1 | Zero flag update enable |
| acc_wr | output | 1 | Accumulator write enable |
| x_wr | output | 1 | X register write enable |
| mem_wr | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| done | output | 1 | Outputs valid strobe |

## Verification
Every result, flag and enable is due exactly one clock edge after the `start` that requested it, and `done` rises at that same edge. In idle cycles the enables must be back at 0 one edge after `start` falls. The bench updates its behavioural model on the same rising edge as the design and compares every output two time units after that edge, on every clock, so that each value is checked in the cycle it is due. Inputs change only on falling edges. Directed cases cover the wrap, clear and pass-through corners, and a random run covers all codes, including back-to-back starts.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic [2:0] {
    FN_SHL   = 3'b000,
    FN_ROTL  = 3'b001,
    FN_SHR   = 3'b010,
    FN_ROTR  = 3'b011,
    FN_STX   = 3'b100,
    FN_LDX   = 3'b101,
    FN_DECR  = 3'b110,
    FN_INCR  = 3'b111
  } rsu_fn_e;

  typedef struct packed {
    logic c_upd;
    logic n_upd;
    logic z_upd;
    logic a_wr;
    logic x_wr;
    logic m_wr;
  } rsu_ctl_t;
endpackage

// File: rtl/rsu_shifter.sv
module rsu_shifter #(
  parameter int W = 8
) (
  input  logic         go_right,
  input  logic         rotate,
  input  logic         cin,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         cout
);
  localparam int MSB = W - 1;
  logic fill;

  always_comb begin
    fill = rotate & cin;
    if (go_right) begin
      dout = {fill, din[MSB:1]};
      cout = din[0];
    end else begin
      dout = {din[MSB-1:0], fill};
      cout = din[MSB];
    end
  end
endmodule

// File: rtl/rsu_stepper.sv
module rsu_stepper #(
  parameter int W = 8
) (
  input  logic         up,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] MONE = {W{1'b1}};

  assign dout = din + (up ? ONE : MONE);
endmodule

// File: rtl/rsu_decode.sv
module rsu_decode
  import rsu_pkg::*;
(
  input  logic [2:0] func,
  input  logic       acc_mode,
  output rsu_ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    unique case (rsu_fn_e'(func))
      FN_SHL, FN_ROTL, FN_SHR, FN_ROTR: begin
        ctl.c_upd = 1'b1;
        ctl.n_upd = 1'b1;
        ctl.z_upd = 1'b1;
        ctl.a_wr  = acc_mode;
        ctl.m_wr  = ~acc_mode;
      end
      FN_STX: ctl.m_wr = 1'b1;
      FN_LDX: begin
        ctl.n_upd = 1'b1;
        ctl.z_upd = 1'b1;
        ctl.x_wr  = 1'b1;
      end
      FN_DECR, FN_INCR: begin
        ctl.n_upd = 1'b1;
        ctl.z_upd = 1'b1;
        ctl.m_wr  = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/rmw_shift_unit.sv
module rmw_shift_unit
  import rsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [2:0]   func,
  input  logic [W-1:0] operand,
  input  logic         acc_mode,
  input  logic         carry_in,
  input  logic [W-1:0] x_in,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         neg_out,
  output logic         zero_out,
  output logic         carry_upd,
  output logic         neg_upd,
  output logic         zero_upd,
  output logic         acc_wr,
  output logic         x_wr,
  output logic         mem_wr,
  output logic [W-1:0] mem_wdata,
  output logic         done
);
  localparam int MSB = W - 1;

  logic [W-1:0] sh_res, st_res;
  logic         sh_cout;
  rsu_ctl_t     ctl;
  logic [W-1:0] nxt_res;
  logic         nxt_c;

  rsu_shifter #(.W(W)) u_shift (
    .go_right (func[1]),
    .rotate   (func[0]),
    .cin      (carry_in),
    .din      (operand),
    .dout     (sh_res),
    .cout     (sh_cout)
  );

  rsu_stepper #(.W(W)) u_step (
    .up   (func[0]),
    .din  (operand),
    .dout (st_res)
  );

  rsu_decode u_dec (
    .func     (func),
    .acc_mode (acc_mode),
    .ctl      (ctl)
  );

  always_comb begin
    unique case (func[2:1])
      2'b10:   nxt_res = func[0] ? operand : x_in;
      2'b11:   nxt_res = st_res;
      default: nxt_res = sh_res;
    endcase
    nxt_c = ctl.c_upd ? sh_cout : carry_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      neg_out   <= 1'b0;
      zero_out  <= 1'b0;
      carry_upd <= 1'b0;
      neg_upd   <= 1'b0;
      zero_upd  <= 1'b0;
      acc_wr    <= 1'b0;
      x_wr      <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else if (start) begin
      result    <= nxt_res;
      carry_out <= nxt_c;
      neg_out   <= nxt_res[MSB];
      zero_out  <= (nxt_res == '0);
      carry_upd <= ctl.c_upd;
      neg_upd   <= ctl.n_upd;
      zero_upd  <= ctl.z_upd;
      acc_wr    <= ctl.a_wr;
      x_wr      <= ctl.x_wr;
      mem_wr    <= ctl.m_wr;
      mem_wdata <= ctl.m_wr ? nxt_res : '0;
      done      <= 1'b1;
    end else begin
      carry_upd <= 1'b0;
      neg_upd   <= 1'b0;
      zero_upd  <= 1'b0;
      acc_wr    <= 1'b0;
      x_wr      <= 1'b0;
      mem_wr    <= 1'b0;
      done      <= 1'b0;
    end
  end
endmodule

// File: rtl/rsu_checker.sv
module rsu_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [2:0]   func,
  input logic         carry_in,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         neg_out,
  input logic         zero_out,
  input logic         carry_upd,
  input logic         neg_upd,
  input logic         zero_upd,
  input logic         acc_wr,
  input logic         x_wr,
  input logic         mem_wr,
  input logic [W-1:0] mem_wdata,
  input logic         done
);
  assert_start_done_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start));

  assert_enables_need_done_R8: assert property (@(posedge clk) disable iff (rst)
    (carry_upd | neg_upd | zero_upd | acc_wr | x_wr | mem_wr) |-> done);

  assert_one_target_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_wr, x_wr, mem_wr}));

  assert_mem_data_R4: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_wdata == result));

  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (rst)
    zero_upd |-> (zero_out == (result == '0)));

  assert_neg_flag_R3: assert property (@(posedge clk) disable iff (rst)
    neg_upd |-> (neg_out == result[W-1]));

  assert_store_x_R5: assert property (@(posedge clk) disable iff (rst)
    (start && func == 3'b100) |=>
      (mem_wr && !carry_upd && !neg_upd && !zero_upd && carry_out == $past(carry_in)));

  assert_step_mem_R7: assert property (@(posedge clk) disable iff (rst)
    (start && func[2:1] == 2'b11) |=> (mem_wr && !carry_upd));

  assert_reset_clear_R9: assert property (@(posedge clk)
    $past(rst) |-> (!done && !mem_wr && result == '0 && mem_wdata == '0));
endmodule

bind rmw_shift_unit rsu_checker #(.W(W)) u_rsu_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .func      (func),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out),
  .neg_out   (neg_out),
  .zero_out  (zero_out),
  .carry_upd (carry_upd),
  .neg_upd   (neg_upd),
  .zero_upd  (zero_upd),
  .acc_wr    (acc_wr),
  .x_wr      (x_wr),
  .mem_wr    (mem_wr),
  .mem_wdata (mem_wdata),
  .done      (done)
);

// File: tb/rmw_shift_unit_test.sv
`timescale 1ns/1ps
module rmw_shift_unit_test;
  localparam int W = 8;
  localparam int MOD = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] func = '0;
  logic [W-1:0] operand = '0;
  logic acc_mode = 1'b0;
  logic carry_in = 1'b0;
  logic [W-1:0] x_in = '0;
  logic [W-1:0] result, mem_wdata;
  logic carry_out, neg_out, zero_out, carry_upd, neg_upd, zero_upd;
  logic acc_wr, x_wr, mem_wr, done;

  always #5 clk = ~clk;

  rmw_shift_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .func(func), .operand(operand),
    .acc_mode(acc_mode), .carry_in(carry_in), .x_in(x_in),
    .result(result), .carry_out(carry_out), .neg_out(neg_out), .zero_out(zero_out),
    .carry_upd(carry_upd), .neg_upd(neg_upd), .zero_upd(zero_upd),
    .acc_wr(acc_wr), .x_wr(x_wr), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .done(done)
  );

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit armed = 0;
  string tag = "R9";

  int e_res, e_mdata;
  bit e_c, e_n, e_z, e_cu, e_nu, e_zu, e_aw, e_xw, e_mw, e_done;

  // Behavioural reference, updated on the same edge as the design.
  always @(posedge clk) begin
    armed = 1;
    if (rst) begin
      e_res = 0; e_mdata = 0; e_c = 0; e_n = 0; e_z = 0;
      e_cu = 0; e_nu = 0; e_zu = 0; e_aw = 0; e_xw = 0; e_mw = 0; e_done = 0;
    end else if (start) begin
      int v;
      int ci;
      v = int'(operand);
      ci = int'(carry_in);
      e_cu = 0; e_nu = 1; e_zu = 1; e_aw = 0; e_xw = 0; e_mw = 0;
      e_c = carry_in;
      case (func)
        3'd0: begin e_res = (v * 2) % MOD;           e_c = (v / 128) % 2 == 1; end
        3'd1: begin e_res = (v * 2 + ci) % MOD;      e_c = (v / 128) % 2 == 1; end
        3'd2: begin e_res = v / 2;                   e_c = (v % 2) == 1; end
        3'd3: begin e_res = v / 2 + ci * 128;        e_c = (v % 2) == 1; end
        3'd4: begin e_res = int'(x_in); e_nu = 0; e_zu = 0; e_mw = 1; end
        3'd5: begin e_res = v; e_xw = 1; end
        3'd6: begin e_res = (v + MOD - 1) % MOD; e_mw = 1; end
        default: begin e_res = (v + 1) % MOD; e_mw = 1; end
      endcase
      if (func < 3'd4) begin
        e_cu = 1;
        e_aw = acc_mode;
        e_mw = !acc_mode;
      end
      e_n = e_res >= 128;
      e_z = e_res == 0;
      e_mdata = e_mw ? e_res : 0;
      e_done = 1;
    end else begin
      e_cu = 0; e_nu = 0; e_zu = 0; e_aw = 0; e_xw = 0; e_mw = 0; e_done = 0;
    end
  end

  task automatic cmp_bit(input string name, input bit act, input bit exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, name, act, exp, cycles);
    end
  endtask

  task automatic cmp_byte(input string name, input logic [W-1:0] act, input int exp);
    if (act !== W'(exp)) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h at cycle %0d", tag, name, act, exp, cycles);
    end
  endtask

  // Compare every output every clock, just after the edge.
  always @(posedge clk) begin
    #2;
    cycles++;
    if (armed) begin
      vectors++;
      cmp_byte("result", result, e_res);
      cmp_byte("mem_wdata", mem_wdata, e_mdata);
      cmp_bit("carry_out", carry_out, e_c);
      cmp_bit("neg_out", neg_out, e_n);
      cmp_bit("zero_out", zero_out, e_z);
      cmp_bit("carry_upd", carry_upd, e_cu);
      cmp_bit("neg_upd", neg_upd, e_nu);
      cmp_bit("zero_upd", zero_upd, e_zu);
      cmp_bit("acc_wr", acc_wr, e_aw);
      cmp_bit("x_wr", x_wr, e_xw);
      cmp_bit("mem_wr", mem_wr, e_mw);
      cmp_bit("done", done, e_done);
    end
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic issue(input logic [2:0] f, input logic [W-1:0] d, input bit am,
                       input bit c, input logic [W-1:0] x, input string t);
    @(negedge clk);
    tag = t; start = 1'b1; func = f; operand = d; acc_mode = am; carry_in = c; x_in = x;
  endtask

  task automatic idle(input int n, input string t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tag = t; start = 1'b0;
      operand = W'($urandom); carry_in = 1'($urandom);
    end
  endtask

  initial begin
    tag = "R9";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2, "R8");
    // R1 left shifts
    issue(3'd0, 8'h98, 1, 0, 8'h00, "R1"); idle(1, "R8");
    issue(3'd1, 8'h80, 1, 1, 8'h00, "R1");
    issue(3'd0, 8'h80, 1, 1, 8'h00, "R1");
    // R2 right shifts
    issue(3'd2, 8'h81, 1, 1, 8'h00, "R2");
    issue(3'd3, 8'h81, 1, 1, 8'h00, "R2");
    issue(3'd3, 8'h01, 0, 0, 8'h00, "R2");
    // R4 destination by mode
    issue(3'd1, 8'h3C, 0, 1, 8'h00, "R4");
    issue(3'd2, 8'h3C, 1, 0, 8'h00, "R4");
    // R5 store X, carry pass-through
    issue(3'd4, 8'h55, 1, 1, 8'h0F, "R5");
    issue(3'd4, 8'h00, 0, 0, 8'h80, "R5");
    // R6 and R3 load X clears and sets flags
    issue(3'd5, 8'h80, 0, 1, 8'h00, "R6");
    issue(3'd5, 8'h00, 0, 0, 8'h00, "R3");
    issue(3'd5, 8'h08, 1, 0, 8'h00, "R3");
    // R7 wrap and memory target despite acc_mode
    issue(3'd7, 8'hFF, 1, 1, 8'h00, "R7");
    issue(3'd6, 8'h00, 1, 0, 8'h00, "R7");
    issue(3'd6, 8'h10, 0, 1, 8'h00, "R7");
    issue(3'd7, 8'h10, 0, 0, 8'h00, "R7");
    idle(3, "R8");
    // R9 reset while a start is pending
    issue(3'd7, 8'h7F, 0, 1, 8'h22, "R9");
    @(negedge clk); rst = 1'b1; tag = "R9";
    @(negedge clk); rst = 1'b0; start = 1'b0;
    idle(2, "R9");
    // Random mix of all codes with gaps
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(3) == 0) idle(1, "R8");
      else issue(3'($urandom), W'($urandom), 1'($urandom), 1'($urandom), W'($urandom), "R3");
    end
    idle(3, "R8");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule